// File: doc/BRIEF.md
# Clock output stop controller

This block sits between the free-running internal clocks of a clock generator (a CPU-domain clock, a PCI-domain clock, a reference clock and a buffered memory clock) and the output pins. For each domain it produces a bank of gated copies, plus one free-running copy that never stops. An active-low global halt input stops the gated CPU copies, the gated reference-rate (IOAPIC) copy and every memory clock copy. A separate active-low PCI halt stops only the gated PCI copies. Stops and restarts are glitch-free. An output finishes the high phase it is in, parks low, and comes back with a full high phase.

Each domain has one gating lane. The lane synchronizes the run request into its own clock domain with a flop chain: two stages for the CPU, reference and memory domains, and one stage for the PCI domain, which samples its halt pin on the PCI rising edge. A two-state machine clocked on the falling edge moves between `LANE_PARKED` and `LANE_LIVE`. The *wake* transition (PARKED to LIVE) is taken when the synchronized request is high. The *halt* transition (LIVE to PARKED) is taken when it is low. The gate enable only changes while the source clock is low, so the AND gate that drives the outputs cannot produce a runt pulse.

A mode strap decides what a shared pin does. With strap = 1 the pin is the PCI halt input. With strap = 0 the pin is a reference-rate clock output and the PCI halt is taken as inactive. The strap is captured on the reference clock while reset is held, and it is frozen once reset is released.

Top module: `clkout_stop_ctrl`

## Requirements
- R1: While `rst_n` is low, every gated output is held at 0 and the free-running outputs keep toggling.
- R2: `cpu_free_o`, `pci_free_o` and `apic_free_o` show one rising edge per source clock period, whatever the state of either halt input.
- R3: When `clk_halt_n` falls more than half a period before a `cpu_clk` rising edge, the gated CPU outputs rise on exactly the next two `cpu_clk` rising edges and then hold at 0. The stop latency is therefore 2 to 3 CPU cycles.
- R4: When `clk_halt_n` rises, the first rising edge of the gated CPU outputs falls on the third `cpu_clk` rising edge after the change.
- R5: While `clk_halt_n` is low, `apic_o` and all `mem_o` bits stay at 0. Once it is high again they run at their source rate.
- R6: The gated PCI outputs keep running while `clk_halt_n` is low.
- R7: In strap mode 1, `shared_pin_i` = 0 is sampled on a `pci_clk` rising edge. The gated PCI outputs show that one rising edge and then hold at 0. On return to 1, the first gated PCI rise falls on the second `pci_clk` rising edge after the change.
- R8: A PCI halt has no effect on the gated CPU, IOAPIC or memory outputs.
- R9: With strap 1 captured, `shared_oe_o` = 0 and `shared_clk_o` = 0. With strap 0 captured, `shared_oe_o` = 1, `shared_clk_o` follows `ref_clk`, and `shared_pin_i` has no effect on the gated PCI outputs.
- R10: The strap value is the one present on the last `ref_clk` rising edge while `rst_n` was low. Later changes to `mode_strap` have no effect.
- R11: Outside reset, no gated high pulse is shorter than half a period of its source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cpu_clk | input | 1 | Free-running CPU-domain clock |
| pci_clk | input | 1 | Free-running PCI-domain clock |
| ref_clk | input | 1 | Free-running reference clock |
| mem_clk | input | 1 | Free-running buffered memory clock |
| clk_halt_n | input | 1 | Global halt, active low, asynchronous |
| mode_strap | input | 1 | 1: shared pin is the PCI halt input; 0: shared pin is a clock output |
| shared_pin_i | input | 1 | PCI halt, active low, when strap = 1 |
| cpu_free_o | output | 1 | Free-running CPU copy |
| cpu_o | output | N_CPU | Gated CPU copies |
| pci_free_o | output | 1 | Free-running PCI copy |
| pci_o | output | N_PCI | Gated PCI copies |
| apic_free_o | output | 1 | Free-running reference-rate copy |
| apic_o | output | 1 | Gated reference-rate copy |
| mem_o | output | N_MEM | Gated memory clock copies |
| shared_clk_o | output | 1 | Reference clock driven onto the shared pin when strap = 0 |
| shared_oe_o | output | 1 | Output enable for the shared pin |

## Verification
The assertions assume that the four source clocks run freely with a 50 % duty cycle, that `mode_strap` only matters while reset is held, and that the halt inputs may change at any time relative to any clock. The stimulus changes every asynchronous input on half-nanosecond offsets, which never coincide with an integer-nanosecond clock edge. This keeps each synchronizer sample unambiguous and makes every expected edge count exact. Reset is asserted asynchronously, so the pulse-width monitor only judges pulses that end while reset is high.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    typedef enum logic {
        LANE_PARKED = 1'b0,
        LANE_LIVE   = 1'b1
    } lane_state_e;

    localparam int DEF_SYNC_DEPTH = 2;

endpackage

// File: rtl/halt_sync.sv
module halt_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    localparam int LAST = DEPTH - 1;

    logic [LAST:0] stage;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage <= '0;
                else        stage <= d_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage <= '0;
                else        stage <= {stage[LAST-1:0], d_i};
            end

            // R3
            sync_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(stage[LAST]) |-> $past(stage[LAST-1]));
        end
    endgenerate

    assign q_o = stage[LAST];
endmodule

// File: rtl/gate_lane.sv
module gate_lane
    import clkstop_pkg::*;
#(
    parameter int WIDTH      = 1,
    parameter int SYNC_DEPTH = DEF_SYNC_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_req_i,
    output logic [WIDTH-1:0] gclk_o
);
    logic        run_s;
    logic        gate_en;
    lane_state_e state, state_nx;

    halt_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (run_req_i),
        .q_o   (run_s)
    );

    // state register: falling edge, so the enable only moves while clk is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) state <= LANE_PARKED;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            LANE_PARKED: if (run_s)  state_nx = LANE_LIVE;
            LANE_LIVE:   if (!run_s) state_nx = LANE_PARKED;
            default:     state_nx = LANE_PARKED;
        endcase
    end

    // output process
    always_comb begin
        gate_en = (state == LANE_LIVE);
    end

    assign gclk_o = {WIDTH{clk & gate_en}};

    // R3
    halt_entry_chk: assert property (@(negedge clk) disable iff (!rst_n)
        !run_s |=> (state == LANE_PARKED));

    // R4
    wake_entry_chk: assert property (@(negedge clk) disable iff (!rst_n)
        run_s |=> (state == LANE_LIVE));
endmodule

// File: rtl/strap_capture.sv
module strap_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_i,
    output logic mode_o
);
    logic mode_q;

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= strap_i;
    end

    assign mode_o = mode_q;

    // R10
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_q));
endmodule

// File: rtl/clkout_stop_ctrl.sv
module clkout_stop_ctrl
    import clkstop_pkg::*;
#(
    parameter int N_CPU    = 2,
    parameter int N_PCI    = 6,
    parameter int N_MEM    = 17,
    parameter int CPU_SYNC = 2,
    parameter int PCI_SYNC = 1,
    parameter int REF_SYNC = 2,
    parameter int MEM_SYNC = 2
) (
    input  logic             rst_n,
    input  logic             cpu_clk,
    input  logic             pci_clk,
    input  logic             ref_clk,
    input  logic             mem_clk,
    input  logic             clk_halt_n,
    input  logic             mode_strap,
    input  logic             shared_pin_i,
    output logic             cpu_free_o,
    output logic [N_CPU-1:0] cpu_o,
    output logic             pci_free_o,
    output logic [N_PCI-1:0] pci_o,
    output logic             apic_free_o,
    output logic             apic_o,
    output logic [N_MEM-1:0] mem_o,
    output logic             shared_clk_o,
    output logic             shared_oe_o
);
    logic stop_pin_mode;
    logic pci_run;

    strap_capture u_strap (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .strap_i (mode_strap),
        .mode_o  (stop_pin_mode)
    );

    assign pci_run = stop_pin_mode ? shared_pin_i : 1'b1;

    gate_lane #(.WIDTH(N_CPU), .SYNC_DEPTH(CPU_SYNC)) u_cpu_lane (
        .clk (cpu_clk), .rst_n (rst_n), .run_req_i (clk_halt_n), .gclk_o (cpu_o)
    );

    gate_lane #(.WIDTH(N_PCI), .SYNC_DEPTH(PCI_SYNC)) u_pci_lane (
        .clk (pci_clk), .rst_n (rst_n), .run_req_i (pci_run), .gclk_o (pci_o)
    );

    gate_lane #(.WIDTH(1), .SYNC_DEPTH(REF_SYNC)) u_apic_lane (
        .clk (ref_clk), .rst_n (rst_n), .run_req_i (clk_halt_n), .gclk_o (apic_o)
    );

    gate_lane #(.WIDTH(N_MEM), .SYNC_DEPTH(MEM_SYNC)) u_mem_lane (
        .clk (mem_clk), .rst_n (rst_n), .run_req_i (clk_halt_n), .gclk_o (mem_o)
    );

    assign cpu_free_o   = cpu_clk;
    assign pci_free_o   = pci_clk;
    assign apic_free_o  = ref_clk;
    assign shared_oe_o  = ~stop_pin_mode;
    assign shared_clk_o = ref_clk & ~stop_pin_mode;

    // R9
    shared_out_run_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        shared_oe_o |-> pci_run);
endmodule

// File: tb/clkout_stop_ctrl_test.sv
`timescale 1ns/1ps
module clkout_stop_ctrl_test;
    localparam int N_CPU = 2, N_PCI = 6, N_MEM = 17;
    localparam real T_CPU = 8.0, T_PCI = 30.0, T_REF = 70.0, T_MEM = 10.0;
    localparam real WIN = 840.0;

    logic rst_n = 0, cpu_clk = 0, pci_clk = 0, ref_clk = 0, mem_clk = 0;
    logic clk_halt_n = 1, mode_strap = 1, shared_pin_i = 1;
    logic cpu_free_o, pci_free_o, apic_free_o, apic_o, shared_clk_o, shared_oe_o;
    logic [N_CPU-1:0] cpu_o;
    logic [N_PCI-1:0] pci_o;
    logic [N_MEM-1:0] mem_o;

    always #(T_CPU/2) cpu_clk = ~cpu_clk;
    always #(T_PCI/2) pci_clk = ~pci_clk;
    always #(T_REF/2) ref_clk = ~ref_clk;
    always #(T_MEM/2) mem_clk = ~mem_clk;

    clkout_stop_ctrl #(.N_CPU(N_CPU), .N_PCI(N_PCI), .N_MEM(N_MEM)) uut (
        .rst_n, .cpu_clk, .pci_clk, .ref_clk, .mem_clk, .clk_halt_n, .mode_strap,
        .shared_pin_i, .cpu_free_o, .cpu_o, .pci_free_o, .pci_o, .apic_free_o,
        .apic_o, .mem_o, .shared_clk_o, .shared_oe_o
    );

    // scoreboard
    typedef struct { string tag; int val; } item_t;
    item_t exp_q[$];
    item_t obs_q[$];
    int checks = 0, errors = 0;

    task automatic check(input string tag, input int expv, input int obsv);
        exp_q.push_back('{tag, expv});
        obs_q.push_back('{tag, obsv});
    endtask

    always @(posedge cpu_clk) begin
        while (exp_q.size() > 0 && obs_q.size() > 0) begin
            item_t e;
            item_t o;
            e = exp_q.pop_front();
            o = obs_q.pop_front();
            checks++;
            if (e.val != o.val) begin
                errors++;
                $display("FAIL %s actual %0d expected %0d", e.tag, o.val, e.val);
            end
        end
    end

    // rise counters
    int c_cpu_raw = 0, c_pci_raw = 0, c_cpu_f = 0, c_pci_f = 0, c_apic_f = 0;
    int c_cpu = 0, c_pci = 0, c_apic = 0, c_mem = 0, c_shr = 0;
    always @(posedge cpu_clk)         c_cpu_raw++;
    always @(posedge pci_clk)         c_pci_raw++;
    always @(posedge cpu_free_o)      c_cpu_f++;
    always @(posedge pci_free_o)      c_pci_f++;
    always @(posedge apic_free_o)     c_apic_f++;
    always @(posedge cpu_o[0])        c_cpu++;
    always @(posedge pci_o[N_PCI-1])  c_pci++;
    always @(posedge apic_o)          c_apic++;
    always @(posedge mem_o[N_MEM-1])  c_mem++;
    always @(posedge shared_clk_o)    c_shr++;

    // pulse width monitors (R11)
    realtime t_cpu, t_pci, t_apic, t_mem;
    int bad_w = 0, n_w = 0;
    always @(posedge cpu_o[0])       t_cpu = $realtime;
    always @(posedge pci_o[0])       t_pci = $realtime;
    always @(posedge apic_o)         t_apic = $realtime;
    always @(posedge mem_o[0])       t_mem = $realtime;
    always @(negedge cpu_o[0]) if (rst_n) begin n_w++; if ($realtime - t_cpu < T_CPU/2 - 0.001) bad_w++; end
    always @(negedge pci_o[0]) if (rst_n) begin n_w++; if ($realtime - t_pci < T_PCI/2 - 0.001) bad_w++; end
    always @(negedge apic_o)   if (rst_n) begin n_w++; if ($realtime - t_apic < T_REF/2 - 0.001) bad_w++; end
    always @(negedge mem_o[0]) if (rst_n) begin n_w++; if ($realtime - t_mem < T_MEM/2 - 0.001) bad_w++; end

    int d_cpu, d_pci, d_apic, d_mem, d_shr, d_cpu_f, d_pci_f, d_apic_f;

    task automatic measure();
        int s_cpu = c_cpu, s_pci = c_pci, s_apic = c_apic, s_mem = c_mem, s_shr = c_shr;
        int s_cf = c_cpu_f, s_pf = c_pci_f, s_af = c_apic_f;
        #(WIN);
        d_cpu = c_cpu - s_cpu;   d_pci = c_pci - s_pci;   d_apic = c_apic - s_apic;
        d_mem = c_mem - s_mem;   d_shr = c_shr - s_shr;
        d_cpu_f = c_cpu_f - s_cf; d_pci_f = c_pci_f - s_pf; d_apic_f = c_apic_f - s_af;
    endtask

    task automatic cpu_gap();
        @(negedge cpu_clk);
        #2.5;
    endtask

    task automatic pci_gap();
        @(negedge pci_clk);
        #3.5;
    endtask

    task automatic finish_run();
        repeat (4) @(posedge cpu_clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int s;
        // R1: reset state
        #302.5;
        check("R1 gated cpu in reset", 0, c_cpu);
        check("R1 gated mem/apic/pci in reset", 0, c_mem + c_apic + c_pci);
        check("R1 free cpu runs in reset", 1, int'(c_cpu_f >= 30));
        rst_n = 1;
        #400;
        cpu_gap();
        measure();
        check("R5 cpu running", 105, d_cpu);
        check("R5 mem running", 84, d_mem);
        check("R5 apic running", 12, d_apic);
        check("R6 pci running", 28, d_pci);
        check("R9 strap1 shared clk idle", 0, d_shr);
        check("R9 strap1 oe low", 0, int'(shared_oe_o));

        // R3: global halt
        cpu_gap();
        s = c_cpu;
        clk_halt_n = 0;
        #(6*T_CPU);
        check("R3 cpu rises after halt", 2, c_cpu - s);
        #300;
        measure();
        check("R3 cpu parked", 0, d_cpu);
        check("R5 mem parked", 0, d_mem);
        check("R5 apic parked", 0, d_apic);
        check("R6 pci runs during halt", 28, d_pci);
        check("R2 free cpu", 105, d_cpu_f);
        check("R2 free pci", 28, d_pci_f);
        check("R2 free apic", 12, d_apic_f);
        check("R3 cpu output low while parked", 0, int'(cpu_o));

        // R4: restart
        cpu_gap();
        s = c_cpu_raw;
        clk_halt_n = 1;
        @(posedge cpu_o[0]);
        #1;
        check("R4 restart edge index", 3, c_cpu_raw - s);
        #300;
        measure();
        check("R4 cpu resumed", 105, d_cpu);
        check("R5 mem resumed", 84, d_mem);
        check("R5 apic resumed", 12, d_apic);

        // R7: pci halt
        pci_gap();
        s = c_pci;
        shared_pin_i = 0;
        #(5*T_PCI);
        check("R7 pci rises after halt", 1, c_pci - s);
        measure();
        check("R7 pci parked", 0, d_pci);
        check("R8 cpu unaffected", 105, d_cpu);
        check("R8 mem unaffected", 84, d_mem);
        check("R8 apic unaffected", 12, d_apic);
        check("R2 free pci during pci halt", 28, d_pci_f);
        pci_gap();
        s = c_pci_raw;
        shared_pin_i = 1;
        @(posedge pci_o[N_PCI-1]);
        #1;
        check("R7 pci restart edge index", 2, c_pci_raw - s);

        // R9/R10: strap 0
        cpu_gap();
        rst_n = 0;
        mode_strap = 0;
        #300;
        cpu_gap();
        rst_n = 1;
        #10.5;
        mode_strap = 1;
        shared_pin_i = 0;
        #300;
        cpu_gap();
        measure();
        check("R9 shared clk follows ref", 12, d_shr);
        check("R9 oe high", 1, int'(shared_oe_o));
        check("R10 pin ignored after strap change", 28, d_pci);

        // R11
        check("R11 short pulses", 0, bad_w);
        check("R11 pulses seen", 1, int'(n_w > 100));
        finish_run();
    end
endmodule